// File: doc/BRIEF.md
# Supervised Processor Reset Delay Generator

This block drives the active-low reset line of a baseband processor. It watches two power-good indications, one for the IO rail and one for the memory rail, together with a global powered-on state. Reset is let go only after all three have been true for a programmed number of consecutive clock cycles. The delay counter stands in for an external timing capacitor, so the delay is a count of clock cycles set by an input value.

When either rail leaves regulation, or the system is powered off, reset is pulled low in the same cycle, through a combinational path that does not wait for a clock edge. The counter then clears. Reset can only be let go again after a complete new timeout. At power-up, and while the block's own reset is applied, the reset line is low.

Top module: `rst_delay_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `cpu_rst_n` is low after that edge. The block then starts from a cleared timer.
- R2: While `pwr_on` is low, `cpu_rst_n` is low, whatever the values of `io_pgood` and `mem_pgood`.
- R3: The timer advances only on edges where `pwr_on`, `io_pgood` and `mem_pgood` are all high. `cpu_rst_n` rises after the (D+1)th consecutive such edge, where D is the unsigned value on `dly_cycles`.
- R4: With `dly_cycles` equal to zero, `cpu_rst_n` rises after the first edge at which all three qualifying inputs are high.
- R5: Dropping `io_pgood` forces `cpu_rst_n` low in the same cycle, with no clock edge needed.
- R6: Dropping `mem_pgood` forces `cpu_rst_n` low in the same cycle, with no clock edge needed.
- R7: Any loss of qualification clears the timer to zero. It does not pause. After the loss, a full new run of D+1 qualified edges is needed before release.
- R8: The release delay grows by exactly one cycle per unit of `dly_cycles`, up to the largest value the input can hold.
- R9: Once released, `cpu_rst_n` stays high for as long as all three qualifying inputs stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pwr_on | input | 1 | Global powered-on state, high when the system is on |
| io_pgood | input | 1 | IO rail in regulation |
| mem_pgood | input | 1 | Memory rail in regulation |
| dly_cycles | input | DLY_W | Release delay D; release follows D+1 qualified cycles |
| cpu_rst_n | output | 1 | Active-low processor reset |

## Verification
The assertions assume that all inputs are already synchronous to `clk`. They also assume that `dly_cycles` does not change while a timeout is running, because a change part-way through moves the release point. The bench therefore changes every input a fixed time after a rising edge. It reprograms the delay only while qualification is absent or the block is held in reset. This includes glitches of a single cycle on each rail, both before release and after it.

// File: rtl/rdg_pkg.sv
// Shared types for the reset delay generator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rdg_pkg;

    // Release sequencer states
    typedef enum logic [1:0] {
        ST_HOLD     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_RELEASED = 2'd2
    } rdg_state_e;

endpackage

// File: rtl/rdg_rail_qual.sv
// Combines the powered-on state and the rail power-good flags into one
// qualification level.
// Assumes: all inputs are synchronous to the block clock.
module rdg_rail_qual #(
    parameter int NUM_RAILS = 2
) (
    input  logic                 pwr_on,
    input  logic [NUM_RAILS-1:0] rail_good,
    output logic                 rails_ok
);

    logic [NUM_RAILS:0] chain;

    assign chain[0] = pwr_on;

    // AND chain: every rail must be good on top of the powered-on state
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        assign chain[g+1] = chain[g] & rail_good[g];
    end

    assign rails_ok = chain[NUM_RAILS];

endmodule

// File: rtl/rdg_delay_timer.sv
// Counts consecutive qualified cycles up to the programmed delay. It clears
// on any loss of qualification and saturates at the delay value.
// Assumes: delay_i stays steady while a count is in progress.
module rdg_delay_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DLY_W-1:0] delay_i,
    output logic             done
);

    localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

    logic [DLY_W-1:0] cnt_q;

    // Counter: clear when not running, advance until the delay is reached
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run)            cnt_q <= '0;
        else if (cnt_q < delay_i) cnt_q <= cnt_q + CNT_ONE;
    end

    // Expiry: qualified and the count has reached the programmed delay
    assign done = run && (cnt_q >= delay_i);

    // R7
    timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    // R3
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt_q < delay_i)) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

endmodule

// File: rtl/rdg_release_fsm.sv
// Sequencer that decides when the processor may leave reset. It only
// releases on timer expiry and falls back to hold on any qualification loss.
// Assumes: done is only ever high while rails_ok is high.
module rdg_release_fsm
    import rdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rails_ok,
    input  logic done,
    output logic released
);

    rdg_state_e state_q, state_d;

    // Next-state logic for hold, counting and released
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:     if (rails_ok) state_d = done ? ST_RELEASED : ST_COUNT;
            ST_COUNT:    if (!rails_ok) state_d = ST_HOLD;
                         else if (done) state_d = ST_RELEASED;
            ST_RELEASED: if (!rails_ok) state_d = ST_HOLD;
            default:     state_d = ST_HOLD;
        endcase
    end

    // State register, cleared to hold by the block reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    assign released = (state_q == ST_RELEASED);

    // R3
    release_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> $past(done));

    // R7
    loss_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rails_ok |=> (state_q == ST_HOLD));

endmodule

// File: rtl/rst_delay_gen.sv
// Top level of the supervised reset delay generator. It drives an active-low
// processor reset that rises after a programmed run of cycles with both rails
// in regulation and the system on, and falls at once when any of them drops.
// Assumes: inputs are synchronous to clk; dly_cycles is stable during a count.
module rst_delay_gen
    import rdg_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             io_pgood,
    input  logic             mem_pgood,
    input  logic [DLY_W-1:0] dly_cycles,
    output logic             cpu_rst_n
);

    localparam int NUM_RAILS = 2;

    logic rails_ok;
    logic tmr_done;
    logic released;

    rdg_rail_qual #(.NUM_RAILS(NUM_RAILS)) u_qual (
        .pwr_on    (pwr_on),
        .rail_good ({mem_pgood, io_pgood}),
        .rails_ok  (rails_ok)
    );

    rdg_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rails_ok),
        .delay_i (dly_cycles),
        .done    (tmr_done)
    );

    rdg_release_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rails_ok (rails_ok),
        .done     (tmr_done),
        .released (released)
    );

    // Output gate: the released state alone is not enough, loss drops reset at once
    assign cpu_rst_n = released & rails_ok;

    // R1
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !cpu_rst_n);

    // R2
    rise_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(pwr_on && io_pgood && mem_pgood));

    // R9
    stay_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_n && pwr_on && io_pgood && mem_pgood) |=>
            (cpu_rst_n || !(pwr_on && io_pgood && mem_pgood)));

endmodule

// File: tb/rst_delay_gen_bench.sv
module rst_delay_gen_bench;

    localparam int DLY_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_on = 1'b0;
    logic             io_pgood = 1'b0;
    logic             mem_pgood = 1'b0;
    logic [DLY_W-1:0] dly_cycles = '0;
    logic             cpu_rst_n;

    int    checks = 0;
    int    fails = 0;
    int    consec = 0;
    int    cycles = 0;
    bit    cmp_en = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    rst_delay_gen #(.DLY_W(DLY_W)) u_rst_delay_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_on     (pwr_on),
        .io_pgood   (io_pgood),
        .mem_pgood  (mem_pgood),
        .dly_cycles (dly_cycles),
        .cpu_rst_n  (cpu_rst_n)
    );

    // Reference model: number of consecutive qualified edges since the last loss
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n || !(pwr_on && io_pgood && mem_pgood)) consec = 0;
        else consec = consec + 1;
    end

    function automatic logic expected();
        return (pwr_on && io_pgood && mem_pgood) && (consec >= int'(dly_cycles) + 1);
    endfunction

    // Per-cycle compare, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (cpu_rst_n !== expected()) begin
                fails++;
                $display("FAIL %s cycle %0d: cpu_rst_n=%b expected %b", cur_req, cycles,
                         cpu_rst_n, expected());
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cpu_rst_n=%b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic i, input logic m);
        @(posedge clk);
        #2;
        pwr_on = p; io_pgood = i; mem_pgood = m;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Watchdog
    initial begin
        wait (cycles > 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset with everything qualified
        cur_req = "R1";
        pwr_on = 1'b1; io_pgood = 1'b1; mem_pgood = 1'b1; dly_cycles = 16'd3;
        idle(3);
        cmp_en = 1'b1;
        idle(5);
        #1 chk("R1", cpu_rst_n, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 1'b1);

        // R2: powered off keeps reset low with good rails
        cur_req = "R2";
        idle(20);
        #1 chk("R2", cpu_rst_n, 1'b0);

        // R3: delay of 5 gives release after 6 qualified edges
        cur_req = "R3";
        dly_cycles = 16'd5;
        drive(1'b1, 1'b1, 1'b1);
        idle(5);
        #1 chk("R3", cpu_rst_n, 1'b0);
        idle(1);
        #1 chk("R3", cpu_rst_n, 1'b1);

        // R9: stays released
        cur_req = "R9";
        idle(30);
        #1 chk("R9", cpu_rst_n, 1'b1);

        // R5: IO drop forces low in the same cycle, then a full timeout again
        cur_req = "R5";
        io_pgood = 1'b0;
        #1 chk("R5", cpu_rst_n, 1'b0);
        drive(1'b1, 1'b1, 1'b1);
        cur_req = "R7";
        idle(20);

        // R6: memory drop forces low in the same cycle
        cur_req = "R6";
        mem_pgood = 1'b0;
        #1 chk("R6", cpu_rst_n, 1'b0);
        drive(1'b1, 1'b1, 1'b1);

        // R7: one-cycle glitch part-way through a count restarts it from zero
        cur_req = "R7";
        idle(3);
        mem_pgood = 1'b0;
        drive(1'b1, 1'b1, 1'b1);
        idle(5);
        #1 chk("R7", cpu_rst_n, 1'b0);
        idle(1);
        #1 chk("R7", cpu_rst_n, 1'b1);
        io_pgood = 1'b0;
        drive(1'b1, 1'b1, 1'b1);
        idle(4);
        io_pgood = 1'b0;
        drive(1'b1, 1'b1, 1'b1);
        idle(10);

        // R4: zero delay releases one cycle after qualification
        cur_req = "R4";
        drive(1'b0, 1'b1, 1'b1);
        dly_cycles = 16'd0;
        drive(1'b1, 1'b1, 1'b1);
        #1 chk("R4", cpu_rst_n, 1'b0);
        idle(1);
        #1 chk("R4", cpu_rst_n, 1'b1);
        idle(5);

        // R8: several delay values, including the largest
        cur_req = "R8";
        foreach (dly_tab[k]) begin
            drive(1'b0, 1'b0, 1'b0);
            dly_cycles = dly_tab[k];
            drive(1'b1, 1'b1, 1'b1);
            idle(int'(dly_tab[k]));
            #1 chk("R8", cpu_rst_n, 1'b0);
            idle(1);
            #1 chk("R8", cpu_rst_n, 1'b1);
        end

        // R2: power-off while released drops reset at once
        cur_req = "R2";
        pwr_on = 1'b0;
        #1 chk("R2", cpu_rst_n, 1'b0);
        drive(1'b0, 1'b1, 1'b1);
        dly_cycles = 16'd2;
        idle(5);
        drive(1'b1, 1'b1, 1'b1);
        idle(10);

        // R1: block reset during release
        cur_req = "R1";
        rst_n = 1'b0;
        idle(2);
        #1 chk("R1", cpu_rst_n, 1'b0);
        rst_n = 1'b1;
        idle(10);
        #1 chk("R1", cpu_rst_n, 1'b1);

        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [DLY_W-1:0] dly_tab [4] = '{16'd1, 16'd10, 16'd200, 16'hFFFF};

endmodule